// File: doc/BRIEF.md
# Performance Counter Overflow Interrupt Enable

This block keeps the per-counter interrupt enables for a bank of performance counters and turns them, together with the counters' overflow flags, into one interrupt request. The enable state is 64 bits wide and has two write views. Writing through the set view turns on every enable written as one. Writing through the clear view turns off every enable written as one. Bits written as zero are left alone in both views. A read returns the same state whichever view is selected.

Each bit position belongs to one counter. Event counters use the low bits, the cycle counter uses bit 31, and an optional instruction counter uses bit 32. Build-time parameters set how many event counters exist and whether the instruction counter exists. Bits with no counter behind them stay at zero. The interrupt request is the OR of enable AND overflow over all implemented bits, and it is registered for one cycle.

Top module: `pmu_irq_enable`

## Requirements
- R1: After reset, every enable reads 0 and `irq` is 0.
- R2: A write with `wr_clr`=0 (set view) sets each implemented enable whose `wr_data` bit is 1.
- R3: A write with `wr_clr`=1 (clear view) clears each implemented enable whose `wr_data` bit is 1.
- R4: An enable whose `wr_data` bit is 0 keeps its value in both views. With `wr_en`=0, no enable changes.
- R5: `rd_data[63:33]` always reads 0, and writes to those bits have no effect.
- R6: Bit 32 is the instruction counter enable and exists only when `HAS_INSTR`=1. Otherwise it reads 0 and ignores writes.
- R7: Event enable bits at positions `NUM_EVT` to 30 read 0 and ignore writes. Overflow flags at unimplemented positions never raise `irq`.
- R8: `rd_data` shows the current state of every implemented enable, and it does not depend on the value of `wr_clr`.
- R9: Bit m (m < `NUM_EVT`) is the enable of event counter m, and bit 31 is the enable of the cycle counter.
- R10: On every clock edge, `irq` takes the OR over all implemented bits of (enable AND `ovf_flags`), using the enables held before that edge. `irq` changes only at clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_clr | input | 1 | Write view select: 0 = set view, 1 = clear view |
| wr_data | input | 64 | Write data; each 1 acts on the enable at that position |
| ovf_flags | input | 64 | Overflow flags, at the same bit positions as the enables |
| rd_data | output | 64 | Current enable state |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds two instances that share the same stimulus. The first has 6 event counters and the instruction counter. It shows the gap between bit 5 and bit 31, where writes and overflow flags must be dropped, and it shows a live bit 32. The second has all 31 event counters and no instruction counter. It shows the full event range up to bit 30, and it shows bit 32 held at zero even when that bit is written or flagged.

// File: rtl/pmu_irq_enable.sv
module pmu_irq_enable #(
  parameter int NUM_EVT   = 31,
  parameter bit HAS_INSTR = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_clr,
  input  logic [63:0] wr_data,
  input  logic [63:0] ovf_flags,
  output logic [63:0] rd_data,
  output logic        irq
);
  localparam logic [63:0] EVT_MASK = (NUM_EVT == 0) ? 64'd0 : ({64{1'b1}} >> (64 - NUM_EVT));
  localparam logic [63:0] CYC_MASK = 64'h0000_0000_8000_0000;
  localparam logic [63:0] INS_MASK = HAS_INSTR ? 64'h0000_0001_0000_0000 : 64'd0;
  localparam logic [63:0] IMPL     = EVT_MASK | CYC_MASK | INS_MASK;

  logic [63:0] en_q;
  logic [63:0] hit;

  assign hit     = wr_data & IMPL;
  assign rd_data = en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      irq  <= 1'b0;
    end else begin
      if (wr_en) en_q <= wr_clr ? (en_q & ~hit) : (en_q | hit);
      irq <= |(en_q & ovf_flags & IMPL);
    end
  end

  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data == 64'd0 && !irq));

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_clr) |=> ((rd_data & $past(hit)) == $past(hit)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_clr) |=> ((rd_data & $past(hit)) == 64'd0));

  assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((rd_data ^ $past(rd_data)) & ~$past(wr_data)) == 64'd0));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[63:33] == 31'd0);

  assert_unimpl_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~IMPL) == 64'd0);

  assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(rd_data) & $past(ovf_flags) & IMPL)));

  generate
    if (!HAS_INSTR) begin : g_no_instr
      assert_no_instr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[32] == 1'b0);
    end
  endgenerate
endmodule

// File: tb/pmu_irq_enable_tb_top.sv
module pmu_irq_enable_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_clr = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] ovf_flags = '0;
  logic [63:0] rd_a, rd_b;
  logic        irq_a, irq_b;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pmu_irq_enable #(.NUM_EVT(6), .HAS_INSTR(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_clr(wr_clr),
    .wr_data(wr_data), .ovf_flags(ovf_flags), .rd_data(rd_a), .irq(irq_a));

  pmu_irq_enable #(.NUM_EVT(31), .HAS_INSTR(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_clr(wr_clr),
    .wr_data(wr_data), .ovf_flags(ovf_flags), .rd_data(rd_b), .irq(irq_b));

  typedef struct packed {
    logic        clr;
    logic [63:0] wd;
    logic [63:0] ovf;
    logic [63:0] exp_rd;
    logic        exp_irq;
  } vec_t;

  // Expected values for dut_i: 6 event counters plus the instruction counter
  localparam vec_t TBL [9] = '{
    '{1'b0, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0005, 1'b1}, // R2 R9
    '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h0000_0001_8000_003F, 1'b0}, // R5 R7
    '{1'b1, 64'h0000_0000_8000_0001, 64'h0000_0000_8000_0000, 64'h0000_0001_0000_003E, 1'b0}, // R3 R9
    '{1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0002, 64'h0000_0001_0000_003E, 1'b1}, // R4
    '{1'b1, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_003E, 1'b0}, // R6
    '{1'b0, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_003E, 1'b1}, // R6
    '{1'b0, 64'hFFFF_FFFE_7FFF_FFC0, 64'hFFFF_FFFE_7FFF_FFC0, 64'h0000_0001_0000_003E, 1'b0}, // R5 R7
    '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b0}, // R3
    '{1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 1'b1}  // R9 R10
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Inputs change at a negedge; outputs are sampled one full cycle later
  task automatic step(input logic we, input logic c, input logic [63:0] wd, input logic [63:0] ov);
    wr_en = we; wr_clr = c; wr_data = wd; ovf_flags = ov;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rd a", rd_a, 64'd0);
    chk("R1 irq a", {63'd0, irq_a}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd b", rd_b, 64'd0);
    chk("R1 irq b", {63'd0, irq_b}, 64'd0);

    for (int i = 0; i < 9; i++) begin
      step(1'b1, TBL[i].clr, TBL[i].wd, TBL[i].ovf);
      chk($sformatf("R2 R3 R4 R5 R6 R7 R9 row %0d rd", i), rd_a, TBL[i].exp_rd);
      step(1'b0, 1'b0, 64'd0, TBL[i].ovf);
      chk($sformatf("R4 row %0d rd hold", i), rd_a, TBL[i].exp_rd);
      chk($sformatf("R10 row %0d irq", i), {63'd0, irq_a}, {63'd0, TBL[i].exp_irq});
    end

    // R10: irq is registered and does not follow ovf_flags between edges
    ovf_flags = 64'd0;
    #1;
    chk("R10 irq holds until edge", {63'd0, irq_a}, 64'd1);
    @(negedge clk);
    chk("R10 irq falls after edge", {63'd0, irq_a}, 64'd0);

    // R8: changing the view select without a write leaves the read unchanged
    wr_clr = 1'b1;
    #1;
    chk("R8 view select clr", rd_a, 64'h0000_0000_8000_0000);
    wr_clr = 1'b0;
    #1;
    chk("R8 view select set", rd_a, 64'h0000_0000_8000_0000);
    step(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    chk("R4 no write with wr_en low", rd_a, 64'h0000_0000_8000_0000);

    // Reset in the middle of a run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset rd", rd_a, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 / R7 with the second build (31 events, no instruction counter)
    step(1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    chk("R6 bit32 absent rd b", rd_b, 64'h0000_0000_FFFF_FFFF);
    chk("R6 bit32 present rd a", rd_a, 64'h0000_0001_8000_003F);
    step(1'b0, 1'b0, 64'd0, 64'h0000_0001_0000_0000);
    step(1'b0, 1'b0, 64'd0, 64'h0000_0001_0000_0000);
    chk("R6 flag 32 no irq b", {63'd0, irq_b}, 64'd0);
    chk("R6 flag 32 irq a", {63'd0, irq_a}, 64'd1);
    step(1'b0, 1'b0, 64'd0, 64'h0000_0000_4000_0000);
    chk("R9 event 30 irq b", {63'd0, irq_b}, 64'd1);
    chk("R7 unimpl event 30 no irq a", {63'd0, irq_a}, 64'd0);
    step(1'b1, 1'b1, 64'h0000_0000_3FFF_FFFF, 64'h0000_0000_4000_0000);
    chk("R3 clear events b", rd_b, 64'h0000_0000_C000_0000);
    chk("R8 clear view read a", rd_a, 64'h0000_0001_8000_0000);

    finish_run();
  end
endmodule